// File: doc/BRIEF.md
# Cascaded Interrupt Controller Command-Word Sequencer

This block is the programming front end for a master/slave pair of 8259-style interrupt controllers on a byte-wide I/O bus. It decodes reads and writes to each controller's even and odd command ports, including their repeated alias windows. It steps each controller through the three initialization words that follow a start word. It keeps the mask, the operation control state and a separate edge/level trigger select byte for each controller.

The resolved configuration goes to the priority and acknowledge logic, which sits outside this block. That configuration is the vector base, the cascade byte, the mode byte, the mask, the lowest-priority level, the special mask flag, the last operation command with a one-cycle strobe, and the trigger select bits. Reads return IRR or ISR on the even port, the mask on the odd port and the trigger byte at its own port. IRR and ISR come in as inputs.

Top module: `pic_cmd_sequencer`

## Requirements
- R1: The master even port decodes at 20h+4k and its odd port at 21h+4k, for k = 0..7. The slave ports decode in the same way at A0h+4k and A1h+4k. An address with bit 1 set, or outside these windows, hits nothing: a read of it returns 00h and a write to it changes no state.
- R2: An even-port write with data bit 4 = 1 starts initialization, whatever bits 7:5 hold. On the next cycle the mask is 00h, the lowest-priority level is 7, the cascade byte is 07h, special mask is off, the read source is IRR and the done flag is 0.
- R3: After a start word, the next three odd-port writes are taken in order. The first is ICW2, whose bits 7:3 appear as the vector base. The second is ICW3, the cascade byte. The third is ICW4, the mode byte. The done flag sets after the third.
- R4: Once done is set, an odd-port write loads the mask. An odd-port read returns the mask.
- R5: When done is set and no sequence is running, an even write with bits 4:3 = 00 is an operation command. It is stored, and it raises its strobe for exactly the next cycle. If its bits 7:6 = 11, its bits 2:0 become the lowest-priority level.
- R6: When done is set and no sequence is running, an even write with bits 4:3 = 01 is a read/mask control word. If its bit 1 = 1, bit 0 selects the read source (0 = IRR, 1 = ISR). If its bit 6 = 1, bit 5 sets special mask. An even-port read returns the selected source.
- R7: Operation and control writes are ignored, with no change to the stored state or the strobe, in two cases: before a controller's first completed initialization, and for even-port writes while a sequence is running.
- R8: The trigger select bytes are at 4D0h (master) and 4D1h (slave). They are read/write, reset to 00h, and do not depend on the initialization state.
- R9: After reset, each controller has mask 00h, mode 01h, stored command 20h, cascade 07h, vector base 0, lowest-priority level 7, read source IRR, special mask off and done 0.
- R10: A start word written during a running sequence restarts that sequence, so the next odd write is again taken as ICW2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Byte write strobe, one cycle per write |
| io_rd | input | 1 | Read enable; read data is combinational |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 00h when nothing is hit |
| irr_in | input | 16 | Request status, slave in [15:8] |
| isr_in | input | 16 | In-service status, slave in [15:8] |
| mask_out | output | 16 | Interrupt masks |
| trig_out | output | 16 | Edge/level trigger select bytes |
| vec_base_out | output | 10 | Vector base, 5 bits per controller |
| cascade_out | output | 16 | Cascade configuration bytes |
| mode_out | output | 16 | Mode bytes |
| low_prio_out | output | 6 | Lowest-priority level, 3 bits per controller |
| smm_out | output | 2 | Special mask mode flags |
| ocw2_out | output | 16 | Last accepted operation command bytes |
| ocw2_stb | output | 2 | One-cycle strobe per accepted command |
| init_done | output | 2 | Initialization complete flags |

## Verification
The assertions assume that the bus raises at most one strobe per cycle and that each write lasts one cycle. They also assume that any address that hits selects exactly one register across both controllers. The bench drives every access from a single task, so only one strobe is ever high at a time. Its addresses are aligned port numbers. Reads sample combinational data mid-cycle, while the address is held steady.

// File: rtl/pic_seq_pkg.sv
package pic_seq_pkg;
    localparam int BYTE_W    = 8;
    localparam int VEC_W     = 5;
    localparam int PRIO_W    = 3;
    localparam int WIN_STEP  = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_WAIT2 = 2'd1,
        SEQ_WAIT3 = 2'd2,
        SEQ_WAIT4 = 2'd3
    } seq_e;

    typedef struct packed {
        seq_e              seq;
        logic              done;
        logic [BYTE_W-1:0] mask;
        logic [VEC_W-1:0]  vec;
        logic [BYTE_W-1:0] casc;
        logic [BYTE_W-1:0] mode;
        logic [BYTE_W-1:0] ocw2;
        logic [BYTE_W-1:0] trig;
        logic              ocw2_stb;
        logic [PRIO_W-1:0] low;
        logic              smm;
        logic              rd_isr;
    } ctl_state_t;

    function automatic logic [15:0] cmd_base(input int idx);
        return 16'(16'h0020 + idx * 128);
    endfunction

    function automatic logic [15:0] trig_port(input int idx);
        return 16'(16'h04D0 + idx);
    endfunction
endpackage

// File: rtl/pic_port_decode.sv
module pic_port_decode
    import pic_seq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int NUM_CTL = 2,
    parameter int ALIASES = 8
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_CTL-1:0] hit_even,
    output logic [NUM_CTL-1:0] hit_odd,
    output logic [NUM_CTL-1:0] hit_trig
);
    localparam int SPAN = ALIASES * WIN_STEP;

    for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
        logic [ADDR_W-1:0] off_w;
        logic              in_win;
        assign off_w       = addr - ADDR_W'(cmd_base(g));
        assign in_win      = (off_w < ADDR_W'(SPAN)) && !off_w[1];
        assign hit_even[g] = in_win && !off_w[0];
        assign hit_odd[g]  = in_win &&  off_w[0];
        assign hit_trig[g] = (addr == ADDR_W'(trig_port(g)));
    end
endmodule

// File: rtl/pic_ctl_regs.sv
module pic_ctl_regs
    import pic_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_even,
    input  logic              wr_odd,
    input  logic              wr_trig,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] irr,
    input  logic [BYTE_W-1:0] isr,
    output ctl_state_t        state,
    output logic [BYTE_W-1:0] rd_even,
    output logic [BYTE_W-1:0] rd_odd
);
    localparam ctl_state_t RST_VAL = '{
        seq: SEQ_IDLE, done: 1'b0, mask: '0, vec: '0, casc: 8'h07,
        mode: 8'h01, ocw2: 8'h20, trig: '0, ocw2_stb: 1'b0,
        low: 3'd7, smm: 1'b0, rd_isr: 1'b0
    };

    ctl_state_t st_d, st_q;
    logic       operating;

    assign operating = (st_q.seq == SEQ_IDLE) && st_q.done;

    always_comb begin
        st_d          = st_q;
        st_d.ocw2_stb = 1'b0;
        if (wr_trig) st_d.trig = wdata;
        if (wr_even) begin
            if (wdata[4]) begin
                st_d.seq    = SEQ_WAIT2;
                st_d.done   = 1'b0;
                st_d.mask   = '0;
                st_d.low    = 3'd7;
                st_d.casc   = 8'h07;
                st_d.smm    = 1'b0;
                st_d.rd_isr = 1'b0;
            end else if (operating) begin
                if (!wdata[3]) begin
                    st_d.ocw2     = wdata;
                    st_d.ocw2_stb = 1'b1;
                    if (wdata[7:6] == 2'b11) st_d.low = wdata[2:0];
                end else begin
                    if (wdata[1]) st_d.rd_isr = wdata[0];
                    if (wdata[6]) st_d.smm    = wdata[5];
                end
            end
        end
        if (wr_odd) begin
            unique case (st_q.seq)
                SEQ_WAIT2: begin st_d.vec  = wdata[7:3]; st_d.seq = SEQ_WAIT3; end
                SEQ_WAIT3: begin st_d.casc = wdata;      st_d.seq = SEQ_WAIT4; end
                SEQ_WAIT4: begin
                    st_d.mode = wdata;
                    st_d.seq  = SEQ_IDLE;
                    st_d.done = 1'b1;
                end
                default: if (st_q.done) st_d.mask = wdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
    end

    assign state   = st_q;
    assign rd_even = st_q.rd_isr ? isr : irr;
    assign rd_odd  = st_q.mask;

    assert_icw1_effects_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_even && wdata[4]) |=> (st_q.mask == '0 && st_q.low == 3'd7 &&
            st_q.casc == 8'h07 && !st_q.smm && !st_q.rd_isr && !st_q.done));

    assert_icw2_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_odd && st_q.seq == SEQ_WAIT2) |=> (st_q.seq == SEQ_WAIT3 && st_q.vec == $past(wdata[7:3])));

    assert_done_after_icw4_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> $past(wr_odd));

    assert_ocw_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_even && !wdata[4] && !operating) |=>
            ($stable(st_q.ocw2) && !st_q.ocw2_stb && $stable(st_q.low) && $stable(st_q.smm)));

    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_odd && st_q.seq == SEQ_IDLE && !st_q.done) |=> $stable(st_q.mask));

    assert_stb_needs_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ocw2_stb |-> st_q.done);

    assert_trig_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_trig |=> $stable(st_q.trig));
endmodule

// File: rtl/pic_cmd_sequencer.sv
module pic_cmd_sequencer
    import pic_seq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int NUM_CTL = 2,
    parameter int ALIASES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       io_wr,
    input  logic                       io_rd,
    input  logic [ADDR_W-1:0]          io_addr,
    input  logic [BYTE_W-1:0]          io_wdata,
    output logic [BYTE_W-1:0]          io_rdata,
    input  logic [NUM_CTL*BYTE_W-1:0]  irr_in,
    input  logic [NUM_CTL*BYTE_W-1:0]  isr_in,
    output logic [NUM_CTL*BYTE_W-1:0]  mask_out,
    output logic [NUM_CTL*BYTE_W-1:0]  trig_out,
    output logic [NUM_CTL*VEC_W-1:0]   vec_base_out,
    output logic [NUM_CTL*BYTE_W-1:0]  cascade_out,
    output logic [NUM_CTL*BYTE_W-1:0]  mode_out,
    output logic [NUM_CTL*PRIO_W-1:0]  low_prio_out,
    output logic [NUM_CTL-1:0]         smm_out,
    output logic [NUM_CTL*BYTE_W-1:0]  ocw2_out,
    output logic [NUM_CTL-1:0]         ocw2_stb,
    output logic [NUM_CTL-1:0]         init_done
);
    logic [NUM_CTL-1:0] hit_even, hit_odd, hit_trig;
    logic [BYTE_W-1:0]  rd_even [NUM_CTL];
    logic [BYTE_W-1:0]  rd_odd  [NUM_CTL];
    logic [BYTE_W-1:0]  trig_q  [NUM_CTL];

    pic_port_decode #(.ADDR_W(ADDR_W), .NUM_CTL(NUM_CTL), .ALIASES(ALIASES)) u_dec (
        .addr     (io_addr),
        .hit_even (hit_even),
        .hit_odd  (hit_odd),
        .hit_trig (hit_trig)
    );

    for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
        ctl_state_t st;
        pic_ctl_regs u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_even (io_wr && hit_even[g]),
            .wr_odd  (io_wr && hit_odd[g]),
            .wr_trig (io_wr && hit_trig[g]),
            .wdata   (io_wdata),
            .irr     (irr_in[g*BYTE_W +: BYTE_W]),
            .isr     (isr_in[g*BYTE_W +: BYTE_W]),
            .state   (st),
            .rd_even (rd_even[g]),
            .rd_odd  (rd_odd[g])
        );
        assign trig_q[g]                          = st.trig;
        assign mask_out[g*BYTE_W +: BYTE_W]       = st.mask;
        assign trig_out[g*BYTE_W +: BYTE_W]       = st.trig;
        assign vec_base_out[g*VEC_W +: VEC_W]     = st.vec;
        assign cascade_out[g*BYTE_W +: BYTE_W]    = st.casc;
        assign mode_out[g*BYTE_W +: BYTE_W]       = st.mode;
        assign low_prio_out[g*PRIO_W +: PRIO_W]   = st.low;
        assign smm_out[g]                         = st.smm;
        assign ocw2_out[g*BYTE_W +: BYTE_W]       = st.ocw2;
        assign ocw2_stb[g]                        = st.ocw2_stb;
        assign init_done[g]                       = st.done;
    end

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            for (int g = 0; g < NUM_CTL; g++) begin
                if (hit_even[g]) io_rdata = io_rdata | rd_even[g];
                if (hit_odd[g])  io_rdata = io_rdata | rd_odd[g];
                if (hit_trig[g]) io_rdata = io_rdata | trig_q[g];
            end
        end
    end

    assert_one_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_even, hit_odd, hit_trig}));
endmodule

// File: tb/pic_cmd_sequencer_bench.sv
module pic_cmd_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 41;
    localparam logic [3:0] OP_W = 4'd1;
    localparam logic [3:0] OP_R = 4'd2;

    // {requirement, op, address, data, expected read}
    localparam logic [39:0] VEC [NV] = '{
        {4'd9, OP_R, 16'h0021, 8'h00, 8'h00},  // R9 mask reset
        {4'd7, OP_W, 16'h0021, 8'hFF, 8'h00},  // R7 odd write before init
        {4'd7, OP_R, 16'h0021, 8'h00, 8'h00},  // R7 still 00
        {4'd2, OP_W, 16'h0020, 8'h11, 8'h00},  // R2 start master
        {4'd3, OP_W, 16'h0021, 8'h08, 8'h00},  // R3 ICW2
        {4'd3, OP_W, 16'h0025, 8'h04, 8'h00},  // R3 ICW3 via alias
        {4'd3, OP_W, 16'h0029, 8'h01, 8'h00},  // R3 ICW4 via alias
        {4'd4, OP_W, 16'h003D, 8'hF0, 8'h00},  // R4 mask via last alias
        {4'd4, OP_R, 16'h0021, 8'h00, 8'hF0},  // R4
        {4'd6, OP_R, 16'h0020, 8'h00, 8'h5A},  // R6 IRR default
        {4'd6, OP_W, 16'h0024, 8'h0B, 8'h00},  // R6 select ISR
        {4'd6, OP_R, 16'h0020, 8'h00, 8'h3C},  // R6
        {4'd6, OP_W, 16'h0020, 8'h0A, 8'h00},  // R6 select IRR
        {4'd1, OP_R, 16'h003C, 8'h00, 8'h5A},  // R1 even alias
        {4'd1, OP_R, 16'h0022, 8'h00, 8'h00},  // R1 bit1 set
        {4'd1, OP_W, 16'h0023, 8'h55, 8'h00},  // R1 write not decoded
        {4'd1, OP_R, 16'h0021, 8'h00, 8'hF0},  // R1 mask untouched
        {4'd1, OP_R, 16'h0040, 8'h00, 8'h00},  // R1 outside window
        {4'd8, OP_W, 16'h04D0, 8'h0C, 8'h00},  // R8
        {4'd8, OP_R, 16'h04D0, 8'h00, 8'h0C},  // R8
        {4'd8, OP_R, 16'h04D1, 8'h00, 8'h00},  // R8
        {4'd7, OP_W, 16'h00A1, 8'h77, 8'h00},  // R7 slave before init
        {4'd7, OP_R, 16'h00A1, 8'h00, 8'h00},  // R7
        {4'd2, OP_W, 16'h00A0, 8'hF1, 8'h00},  // R2 bits 7:5 ignored
        {4'd3, OP_W, 16'h00A1, 8'h70, 8'h00},  // R3
        {4'd3, OP_W, 16'h00A5, 8'h02, 8'h00},  // R3
        {4'd3, OP_W, 16'h00A9, 8'h01, 8'h00},  // R3
        {4'd4, OP_W, 16'h00BD, 8'h3E, 8'h00},  // R4
        {4'd4, OP_R, 16'h00A1, 8'h00, 8'h3E},  // R4
        {4'd6, OP_W, 16'h00A4, 8'h0B, 8'h00},  // R6
        {4'd6, OP_R, 16'h00BC, 8'h00, 8'h81},  // R6 slave ISR
        {4'd6, OP_R, 16'h0020, 8'h00, 8'h5A},  // R6 master unaffected
        {4'd2, OP_W, 16'h0020, 8'h13, 8'h00},  // R2 restart master
        {4'd2, OP_R, 16'h0021, 8'h00, 8'h00},  // R2 mask cleared
        {4'd7, OP_W, 16'h0020, 8'h0B, 8'h00},  // R7 OCW3 during sequence
        {4'd3, OP_W, 16'h0021, 8'h20, 8'h00},  // R3
        {4'd3, OP_W, 16'h0021, 8'h07, 8'h00},  // R3
        {4'd3, OP_W, 16'h0021, 8'h03, 8'h00},  // R3
        {4'd7, OP_R, 16'h0020, 8'h00, 8'h5A},  // R7 still IRR
        {4'd8, OP_R, 16'h04D0, 8'h00, 8'h0C},  // R8 kept across init
        {4'd1, OP_R, 16'h00A2, 8'h00, 8'h00}   // R1 slave bit1 set
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [15:0] irr_in = 16'hC35A;
    logic [15:0] isr_in = 16'h813C;
    logic [15:0] mask_out, trig_out, cascade_out, mode_out, ocw2_out;
    logic [9:0]  vec_base_out;
    logic [5:0]  low_prio_out;
    logic [1:0]  smm_out, ocw2_stb, init_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_cmd_sequencer u_pic_cmd_sequencer (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .irr_in(irr_in), .isr_in(isr_in), .mask_out(mask_out),
        .trig_out(trig_out), .vec_base_out(vec_base_out),
        .cascade_out(cascade_out), .mode_out(mode_out),
        .low_prio_out(low_prio_out), .smm_out(smm_out),
        .ocw2_out(ocw2_out), .ocw2_stb(ocw2_stb), .init_done(init_done)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        #1;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #(CLK_PERIOD/4);
        d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state at the ports
        check("R9 mask", mask_out, 16'h0000);
        check("R9 mode", mode_out, 16'h0101);
        check("R9 ocw2", ocw2_out, 16'h2020);
        check("R9 cascade", cascade_out, 16'h0707);
        check("R9 low prio", {10'd0, low_prio_out}, 16'h003F);
        check("R9 done", {14'd0, init_done}, 16'h0000);
        check("R8 trig reset", trig_out, 16'h0000);
        check("R9 vec", {6'd0, vec_base_out}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][35:32] == OP_W) begin
                bus_write(VEC[i][31:16], VEC[i][15:8]);
            end else begin
                bus_read(VEC[i][31:16], rd);
                check($sformatf("R%0d vector %0d", VEC[i][39:36], i), {8'd0, rd}, {8'd0, VEC[i][7:0]});
            end
        end

        // R3 exported init words
        check("R3 master vec", {11'd0, vec_base_out[4:0]}, 16'h0004);
        check("R3 slave vec", {11'd0, vec_base_out[9:5]}, 16'h000E);
        check("R3 cascade", cascade_out, 16'h0207);
        check("R3 mode", mode_out, 16'h0103);
        check("R3 done", {14'd0, init_done}, 16'h0003);
        check("R4 slave mask", mask_out, 16'h3E00);

        // R5 operation command with priority set
        bus_write(16'h0020, 8'hC5);
        check("R5 strobe high", {14'd0, ocw2_stb}, 16'h0001);
        check("R5 ocw2", ocw2_out, 16'h20C5);
        check("R5 low prio", {13'd0, low_prio_out[2:0]}, 16'h0005);
        @(negedge clk); #1;
        check("R5 strobe one cycle", {14'd0, ocw2_stb}, 16'h0000);
        bus_write(16'h0020, 8'h20);
        check("R5 no prio change", {13'd0, low_prio_out[2:0]}, 16'h0005);

        // R6 special mask
        bus_write(16'h0020, 8'h68);
        check("R6 smm on", {14'd0, smm_out}, 16'h0001);
        bus_write(16'h0021, 8'h99);
        check("R4 mask load", mask_out, 16'h3E99);

        // R2 start word side effects
        bus_write(16'h0020, 8'h13);
        check("R2 mask", mask_out, 16'h3E00);
        check("R2 low prio", {13'd0, low_prio_out[2:0]}, 16'h0007);
        check("R2 smm", {14'd0, smm_out}, 16'h0000);
        check("R2 cascade", cascade_out, 16'h0207);
        check("R2 done", {14'd0, init_done}, 16'h0002);

        // R10 restart mid-sequence
        bus_write(16'h0021, 8'hA8);
        bus_write(16'h0020, 8'h11);
        bus_write(16'h0021, 8'hB0);
        bus_write(16'h0021, 8'h05);
        check("R10 not done yet", {14'd0, init_done}, 16'h0002);
        bus_write(16'h0021, 8'h01);
        check("R10 vec", {11'd0, vec_base_out[4:0]}, 16'h0016);
        check("R10 cascade", cascade_out, 16'h0205);
        check("R10 done", {14'd0, init_done}, 16'h0003);

        // R7 operation command ignored during slave sequence
        bus_write(16'h00A0, 8'h11);
        bus_write(16'h00A0, 8'hC2);
        check("R7 no strobe", {14'd0, ocw2_stb}, 16'h0000);
        check("R7 slave prio", {13'd0, low_prio_out[5:3]}, 16'h0007);
        check("R7 slave ocw2", ocw2_out, 16'h2020);

        finish_run();
    end
endmodule